// File: doc/BRIEF.md
# Oversampling Resolution Enhancement Averager

This block sits on the sample stream leaving an ADC data path. Depending on a two-bit rate field it either hands each sample on unchanged or gathers a group of consecutive accepted samples and returns one widened result per group. A group of 4 yields one extra bit of resolution and a group of 16 yields two, so the output rate drops to a quarter or a sixteenth of the accepted sample rate.

Averaging is only used when the converter runs at full resolution and is not free-running. With the low-resolution bit or the free-run bit set, the block falls back to pass-through whatever the rate field holds. Any change of the effective mode throws away a partially filled group, so a result never mixes samples that were taken under different settings.

Top module: `os_averager`

## Requirements
- R1: With rate field 0, each accepted sample (smp_valid high) appears zero-extended on res_data with res_valid high in the cycle after it is accepted.
- R2: With rate field 1, every fourth accepted sample completes a group. In the cycle after that sample, res_valid pulses and res_data equals the sum of the 4 samples shifted right by 1, so bit DATA_W+1 of res_data is 0.
- R3: With rate field 2, every sixteenth accepted sample completes a group. In the cycle after that sample, res_valid pulses and res_data equals the sum of the 16 samples shifted right by 2.
- R4: While lowres_mode is 1, the block behaves as in R1 for any rate field value.
- R5: While freerun_mode is 1, the block behaves as in R1 for any rate field value.
- R6: Rate field 3 is reserved and behaves as in R1.
- R7: The effective mode is pass-through, group-of-4 or group-of-16, derived from R1 to R6. When it differs from its value in the previous cycle, the partial group is discarded. A sample accepted in that same cycle counts as the first sample of a new group under the new mode.
- R8: The synchronous reset rst, active high, clears the partial group and the effective mode to pass-through. res_valid is 0 during reset and in the first cycle after it.
- R9: Cycles with smp_valid low do not count toward a group. res_valid is high only in the cycle after a sample that completes a group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid | input | 1 | Sample present this cycle |
| smp_data | input | DATA_W | Converted sample, unsigned |
| rate_sel | input | 2 | 0 pass, 1 group of 4, 2 group of 16, 3 pass |
| lowres_mode | input | 1 | Low-resolution conversion; forces pass-through |
| freerun_mode | input | 1 | Free-running conversion; forces pass-through |
| res_valid | output | 1 | One-cycle pulse per result |
| res_data | output | DATA_W+2 | Widened result, zero-extended |

## Verification
Two functions can fall in the same cycle. One is the discard of a partial group on an effective mode change. The other is the acceptance of a sample, which may also be the sample that completes a group. The bench changes the rate field, and separately the low-resolution and free-run bits, partway through a group and in the same cycle as a valid sample. It also switches to pass-through in that cycle, so that the new sample completes at once. A behavioural model holds the group as a running sum and count, clears them before it adds the colliding sample, and is compared with the outputs on every clock.

// File: rtl/os_avg_pkg.sv
package os_avg_pkg;

  typedef enum logic [1:0] {
    M_PASS  = 2'd0,
    M_AVG4  = 2'd1,
    M_AVG16 = 2'd2
  } avg_mode_e;

  function automatic avg_mode_e decode_mode(input logic [1:0] rate,
                                            input logic       lowres,
                                            input logic       freerun);
    if (lowres || freerun) return M_PASS;
    case (rate)
      2'd1:    return M_AVG4;
      2'd2:    return M_AVG16;
      default: return M_PASS;
    endcase
  endfunction

  function automatic logic [3:0] last_index(input avg_mode_e m);
    case (m)
      M_AVG4:  return 4'd3;
      M_AVG16: return 4'd15;
      default: return 4'd0;
    endcase
  endfunction

endpackage

// File: rtl/os_mode_track.sv
module os_mode_track
  import os_avg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] rate_sel,
  input  logic       lowres_mode,
  input  logic       freerun_mode,
  output avg_mode_e  mode,
  output logic       mode_chg
);
  avg_mode_e prev_q;

  assign mode     = decode_mode(rate_sel, lowres_mode, freerun_mode);
  assign mode_chg = (mode != prev_q);

  always_ff @(posedge clk) begin
    if (rst) prev_q <= M_PASS;
    else     prev_q <= mode;
  end

  // R7: any change is followed by agreement in the next cycle unless inputs move again
  a_r7_prev_follows: assert property (@(posedge clk) disable iff (rst)
    mode_chg |=> (prev_q == $past(mode)));
endmodule

// File: rtl/os_group_accum.sv
module os_group_accum
  import os_avg_pkg::*;
#(
  parameter int DATA_W = 12,
  localparam int ACC_W = DATA_W + 4,
  localparam int OUT_W = DATA_W + 2
)(
  input  logic              clk,
  input  logic              rst,
  input  avg_mode_e         mode,
  input  logic              mode_chg,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] smp_data,
  output logic              grp_done,
  output logic [OUT_W-1:0]  grp_result,
  output logic [3:0]        cnt_q
);
  logic [ACC_W-1:0] acc_q, acc_d, base_acc, sum;
  logic [3:0]       cnt_d, base_cnt, last_idx;

  function automatic logic [OUT_W-1:0] scale_sum(input avg_mode_e m,
                                                 input logic [ACC_W-1:0] s);
    case (m)
      M_AVG4:  return OUT_W'(s >> 1);
      M_AVG16: return OUT_W'(s >> 2);
      default: return OUT_W'(s);
    endcase
  endfunction

  always_comb begin
    last_idx   = last_index(mode);
    base_acc   = mode_chg ? '0 : acc_q;
    base_cnt   = mode_chg ? 4'd0 : cnt_q;
    sum        = base_acc + ACC_W'(smp_data);
    grp_done   = 1'b0;
    grp_result = scale_sum(mode, sum);
    acc_d      = base_acc;
    cnt_d      = base_cnt;
    if (smp_valid) begin
      if (base_cnt == last_idx) begin
        grp_done = 1'b1;
        acc_d    = '0;
        cnt_d    = 4'd0;
      end else begin
        acc_d = sum;
        cnt_d = base_cnt + 4'd1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      cnt_q <= 4'd0;
    end else begin
      acc_q <= acc_d;
      cnt_q <= cnt_d;
    end
  end

  // R9: a settled mode never lets the count run past its group
  a_r9_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    !mode_chg |-> (cnt_q <= last_index(mode)));
  // R7: a mode change leaves at most the colliding sample in the new group
  a_r7_discard: assert property (@(posedge clk) disable iff (rst)
    mode_chg |=> (cnt_q <= 4'd1));
  // R9: idle cycles leave the partial group untouched
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!smp_valid && !mode_chg) |=> $stable(cnt_q));
endmodule

// File: rtl/os_result_reg.sv
module os_result_reg #(
  parameter int OUT_W = 14
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             grp_done,
  input  logic [OUT_W-1:0] grp_result,
  output logic             res_valid,
  output logic [OUT_W-1:0] res_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_data  <= '0;
    end else begin
      res_valid <= grp_done;
      if (grp_done) res_data <= grp_result;
    end
  end

  // R8: nothing emerges in the first cycle after reset
  a_r8_quiet_after_reset: assert property (@(posedge clk)
    $fell(rst) |-> !res_valid);
endmodule

// File: rtl/os_averager.sv
module os_averager
  import os_avg_pkg::*;
#(
  parameter int DATA_W = 12,
  localparam int OUT_W = DATA_W + 2
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] smp_data,
  input  logic [1:0]        rate_sel,
  input  logic              lowres_mode,
  input  logic              freerun_mode,
  output logic              res_valid,
  output logic [OUT_W-1:0]  res_data
);
  avg_mode_e        mode;
  logic             mode_chg;
  logic             grp_done;
  logic [OUT_W-1:0] grp_result;
  logic [3:0]       cnt_q;

  os_mode_track u_mode (
    .clk(clk), .rst(rst), .rate_sel(rate_sel), .lowres_mode(lowres_mode),
    .freerun_mode(freerun_mode), .mode(mode), .mode_chg(mode_chg)
  );

  os_group_accum #(.DATA_W(DATA_W)) u_accum (
    .clk(clk), .rst(rst), .mode(mode), .mode_chg(mode_chg),
    .smp_valid(smp_valid), .smp_data(smp_data), .grp_done(grp_done),
    .grp_result(grp_result), .cnt_q(cnt_q)
  );

  os_result_reg #(.OUT_W(OUT_W)) u_out (
    .clk(clk), .rst(rst), .grp_done(grp_done), .grp_result(grp_result),
    .res_valid(res_valid), .res_data(res_data)
  );

  // R1: a pass-through sample reappears zero-extended one cycle later
  a_r1_pass_echo: assert property (@(posedge clk) disable iff (rst)
    (mode == M_PASS && smp_valid) |=>
      (res_valid && res_data == OUT_W'($past(smp_data))));
  // R2: group-of-4 results never use the top bit
  a_r2_avg4_width: assert property (@(posedge clk) disable iff (rst)
    (res_valid && $past(mode) == M_AVG4) |-> !res_data[OUT_W-1]);
  // R9: a result always follows an accepted sample
  a_r9_needs_sample: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $past(smp_valid));
  // R3: a group-of-16 result only follows the sixteenth sample
  a_r3_full_group: assert property (@(posedge clk) disable iff (rst)
    (res_valid && $past(mode) == M_AVG16) |->
      ($past(cnt_q) == 4'd15 && !$past(mode_chg)));
endmodule

// File: tb/tb_os_averager.sv
module tb_os_averager;
  localparam int DATA_W = 12;
  localparam int OUT_W  = DATA_W + 2;
  localparam time CLK_PERIOD = 10ns;
  localparam int WATCHDOG = 100000;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              smp_valid = 1'b0;
  logic [DATA_W-1:0] smp_data = '0;
  logic [1:0]        rate_sel = 2'd0;
  logic              lowres_mode = 1'b0;
  logic              freerun_mode = 1'b0;
  logic              res_valid;
  logic [OUT_W-1:0]  res_data;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  string tag = "R8";

  // reference model state
  int  m_sum = 0, m_cnt = 0, m_prev = 1;
  bit  exp_v = 0;
  int  exp_d = 0;

  os_averager #(.DATA_W(DATA_W)) dut (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
    .rate_sel(rate_sel), .lowres_mode(lowres_mode), .freerun_mode(freerun_mode),
    .res_valid(res_valid), .res_data(res_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int group_size(logic [1:0] r, logic lr, logic fr);
    if (lr || fr) return 1;
    if (r == 2'd1) return 4;
    if (r == 2'd2) return 16;
    return 1;
  endfunction

  always @(posedge clk) begin
    int g;
    cycles++;
    g = group_size(rate_sel, lowres_mode, freerun_mode);
    exp_v <= 0;
    if (rst) begin
      m_sum = 0; m_cnt = 0; m_prev = 1;
    end else begin
      if (g != m_prev) begin m_sum = 0; m_cnt = 0; end
      m_prev = g;
      if (smp_valid) begin
        m_sum += int'(smp_data);
        m_cnt++;
        if (m_cnt == g) begin
          exp_v <= 1;
          exp_d <= (g == 1) ? m_sum : (g == 4) ? (m_sum >> 1) : (m_sum >> 2);
          m_sum = 0; m_cnt = 0;
        end
      end
    end
  end

  always @(negedge clk) begin
    checks++;
    if (res_valid !== exp_v) begin
      failures++;
      $display("FAIL %s res_valid actual=%0b expected=%0b at cycle %0d", tag, res_valid, exp_v, cycles);
    end else if (exp_v) begin
      checks++;
      if (int'(res_data) != exp_d) begin
        failures++;
        $display("FAIL %s res_data actual=%0d expected=%0d at cycle %0d", tag, res_data, exp_d, cycles);
      end
    end
    if (cycles > WATCHDOG) begin
      failures++;
      $display("FAIL watchdog actual=%0d cycles expected<=%0d", cycles, WATCHDOG);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic send(input int n, input bit gaps, input int fixed);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      smp_valid = 1'b1;
      smp_data  = (fixed >= 0) ? DATA_W'(fixed) : DATA_W'($urandom);
      if (gaps && ($urandom % 3 == 0)) begin
        @(negedge clk);
        smp_valid = 1'b0;
      end
    end
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    tag = "R8"; idle(4);
    @(negedge clk); rst = 1'b0;
    tag = "R1"; rate_sel = 2'd0; send(10, 1'b1, -1); idle(2);
    tag = "R2"; rate_sel = 2'd1; send(8, 1'b0, 4095); send(12, 1'b1, -1); idle(2);
    tag = "R3"; rate_sel = 2'd2; send(16, 1'b0, 4095); send(32, 1'b1, -1); idle(2);
    tag = "R4"; lowres_mode = 1'b1; send(9, 1'b0, -1); idle(2); lowres_mode = 1'b0;
    tag = "R5"; rate_sel = 2'd1; freerun_mode = 1'b1; send(7, 1'b1, -1); idle(2); freerun_mode = 1'b0;
    tag = "R6"; rate_sel = 2'd3; send(6, 1'b0, -1); idle(2);
    // R7: change rate mid-group, colliding with a valid sample
    tag = "R7"; rate_sel = 2'd2; send(7, 1'b0, -1);
    @(negedge clk); smp_valid = 1'b1; smp_data = 12'd100; rate_sel = 2'd1;
    send(3, 1'b0, 200); idle(2);
    send(2, 1'b0, -1);
    @(negedge clk); smp_valid = 1'b1; smp_data = 12'd77; lowres_mode = 1'b1;
    @(negedge clk); smp_valid = 1'b0; lowres_mode = 1'b0;
    send(4, 1'b0, -1);
    send(3, 1'b0, -1);
    @(negedge clk); smp_valid = 1'b1; smp_data = 12'd55; freerun_mode = 1'b1;
    @(negedge clk); smp_valid = 1'b0; freerun_mode = 1'b0;
    send(4, 1'b0, -1); idle(2);
    // R8: reset mid-group discards the partial sum
    tag = "R8"; rate_sel = 2'd2; send(9, 1'b0, -1);
    @(negedge clk); rst = 1'b1; idle(2);
    @(negedge clk); rst = 1'b0;
    tag = "R9"; send(16, 1'b1, -1); send(40, 1'b1, -1); idle(3);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule